// File: doc/BRIEF.md
# Maskable Interrupt Controller with Vectoring

This unit sits beside the decoder of a small 8-bit microcontroller core and decides when the core leaves its normal instruction stream. Two hardware events can raise a request: a one-cycle overflow pulse from the timer, and a falling edge on an external active-low pin. The pin is asynchronous, so it is synchronized before its edge is detected. Each event latches a sticky flag in a status register, whether or not the event is masked and whether or not interrupts are globally enabled. A separate mask register decides which flags may actually interrupt the core.

The decoder sends single-cycle strobes for the enable, disable, return-from-interrupt and software-interrupt instructions. When the global enable is set and either a masked-in flag is pending or a software interrupt strobe arrives, the unit raises `take_o` and presents a fetch vector. Hardware requests go to address 0x001 and software requests go to 0x002. Accepting a request clears the global enable, so a service routine is not re-entered until it executes a return or an enable. Software clears flags by writing the status register. It must do so before interrupts are enabled again.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low and just after it is released, `stat_rdata_o`, `mask_rdata_o`, `gie_o` and `take_o` are all 0.
- R2: A high `tmr_ovf_i` at a clock edge sets the timer flag (bit 0) at that edge, whatever the mask and the global enable are.
- R3: A falling edge on `ext_irq_ni` sets the external flag (bit 3) on the third rising clock edge after the pin falls. A rising edge, or a pin held low, sets nothing.
- R4: `stat_rdata_o` is the bitwise AND of the flags and the mask. Only mask bits 0 and 3 are stored, and all other mask and status bits read as 0.
- R5: A status write keeps the flag bits where the written data has a 1 and clears those where it has a 0. It never sets a flag. An event in the same cycle as a write still sets its flag.
- R6: `eni_i` or `reti_i` sets the global enable on the next edge and `disi_i` clears it. If `disi_i` comes together with either of the others, `disi_i` wins.
- R7: `take_o` is high exactly when the global enable is set and either some flag AND its mask bit is 1 or `swi_i` is high. With no `swi_i`, the vector is 0x001.
- R8: A taken `swi_i` gives the vector 0x002 and wins over a pending hardware request in the same cycle, whose flag stays pending. A `swi_i` with the global enable clear is ignored.
- R9: A cycle with `take_o` high clears the global enable on the next edge, even if `eni_i` or `reti_i` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_irq_ni | input | 1 | External interrupt pin, active low, asynchronous |
| eni_i | input | 1 | Enable-interrupts strobe |
| disi_i | input | 1 | Disable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| swi_i | input | 1 | Software interrupt strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 8 | Status write data (0 bits clear flags) |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| stat_rdata_o | output | 8 | Flags AND mask |
| mask_rdata_o | output | 8 | Mask register contents |
| take_o | output | 1 | Take interrupt now |
| vector_o | output | 12 | Fetch address for the taken interrupt |
| gie_o | output | 1 | Global interrupt enable state |

## Verification
The assertions assume that every decoder strobe, the timer pulse and the register writes are synchronous to `clk_i` and stable around its rising edge. Only the external pin may change at any time. The bench drives all inputs on the falling clock edge. It holds the pin for random stretches so that both lone edges and runs of toggles pass through the synchronizer. It picks strobe combinations at random, including the conflicting ones (disable with enable, software request with a pending hardware flag, a status write with a simultaneous event), so that each priority rule is hit many times.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned TMR_BIT = 0;
  localparam int unsigned EXT_BIT = 3;
  typedef enum logic {SRC_HW = 1'b0, SRC_SW = 1'b1} irq_src_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= pin_ni;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], pin_ni};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_evt_i,
  input  logic              ext_evt_i,
  input  logic              stat_wr_i,
  input  logic [DATA_W-1:0] stat_wdata_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  output logic [DATA_W-1:0] flags_o,
  output logic [DATA_W-1:0] mask_o
);
  import irq_pkg::*;

  localparam logic [DATA_W-1:0] IMPL = DATA_W'((1 << TMR_BIT) | (1 << EXT_BIT));

  logic [DATA_W-1:0] flags_q, mask_q, evt, kept;

  always_comb begin
    evt          = '0;
    evt[TMR_BIT] = tmr_evt_i;
    evt[EXT_BIT] = ext_evt_i;
    kept         = stat_wr_i ? (flags_q & stat_wdata_i) : flags_q;
  end

  // events win over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (kept | evt) & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i & IMPL;

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int unsigned    ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HW_VEC = 12'h001,
  parameter logic [ADDR_W-1:0] SW_VEC = 12'h002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_pend_i,
  input  logic              swi_i,
  input  logic              eni_i,
  input  logic              disi_i,
  input  logic              reti_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              gie_o
);
  import irq_pkg::*;

  logic      gie_q;
  irq_src_e  src;

  assign src      = swi_i ? SRC_SW : SRC_HW;
  assign take_o   = gie_q & (hw_pend_i | swi_i);
  assign vector_o = (src == SRC_SW) ? SW_VEC : HW_VEC;

  // accept > disable > enable/return
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               gie_q <= 1'b0;
    else if (take_o || disi_i) gie_q <= 1'b0;
    else if (eni_i || reti_i)  gie_q <= 1'b1;

  assign gie_o = gie_q;
endmodule

// File: rtl/mcu_irq_ctrl_chk.sv
module mcu_irq_ctrl_chk #(
  parameter int unsigned       DATA_W = 8,
  parameter int unsigned       ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HW_VEC = 12'h001,
  parameter logic [ADDR_W-1:0] SW_VEC = 12'h002
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tmr_ovf_i,
  input logic              swi_i,
  input logic              eni_i,
  input logic              disi_i,
  input logic              reti_i,
  input logic              stat_wr_i,
  input logic [DATA_W-1:0] stat_wdata_i,
  input logic              take_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic              gie_o,
  input logic [DATA_W-1:0] flags_q
);
  import irq_pkg::*;

  AST_TMR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> flags_q[TMR_BIT]); // R2
  AST_WR_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && !flags_q[TMR_BIT] && !tmr_ovf_i |=> !flags_q[TMR_BIT]); // R5
  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && !stat_wdata_i[TMR_BIT] && !tmr_ovf_i |=> !flags_q[TMR_BIT]); // R5
  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> gie_o); // R7
  AST_HW_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !swi_i |-> vector_o == HW_VEC); // R7
  AST_SW_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && swi_i |-> vector_o == SW_VEC); // R8
  AST_SW_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_o && swi_i |-> take_o); // R8
  AST_DISI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disi_i |=> !gie_o); // R6
  AST_ENI_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eni_i || reti_i) && !disi_i && !take_o |=> gie_o); // R6
  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !gie_o); // R9
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl #(
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       ADDR_W      = 12,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] HW_VEC      = 12'h001,
  parameter logic [ADDR_W-1:0] SW_VEC      = 12'h002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_ovf_i,
  input  logic              ext_irq_ni,
  input  logic              eni_i,
  input  logic              disi_i,
  input  logic              reti_i,
  input  logic              swi_i,
  input  logic              stat_wr_i,
  input  logic [DATA_W-1:0] stat_wdata_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  output logic [DATA_W-1:0] stat_rdata_o,
  output logic [DATA_W-1:0] mask_rdata_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              gie_o
);
  logic              ext_fall;
  logic [DATA_W-1:0] flags_q, mask_q, armed;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (ext_irq_ni),
    .fall_o (ext_fall)
  );

  irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tmr_evt_i    (tmr_ovf_i),
    .ext_evt_i    (ext_fall),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .flags_o      (flags_q),
    .mask_o       (mask_q)
  );

  assign armed        = flags_q & mask_q;
  assign stat_rdata_o = armed;
  assign mask_rdata_o = mask_q;

  irq_arb #(.ADDR_W(ADDR_W), .HW_VEC(HW_VEC), .SW_VEC(SW_VEC)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_pend_i (|armed),
    .swi_i     (swi_i),
    .eni_i     (eni_i),
    .disi_i    (disi_i),
    .reti_i    (reti_i),
    .take_o    (take_o),
    .vector_o  (vector_o),
    .gie_o     (gie_o)
  );
endmodule

bind mcu_irq_ctrl mcu_irq_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HW_VEC(HW_VEC), .SW_VEC(SW_VEC)
) u_chk (.*);

// File: tb/mcu_irq_ctrl_tb.sv
`timescale 1ns/1ps
module mcu_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tmr_ovf_i, ext_irq_ni, eni_i, disi_i, reti_i, swi_i;
  logic        stat_wr_i, mask_wr_i;
  logic [7:0]  stat_wdata_i, mask_wdata_i, stat_rdata_o, mask_rdata_o;
  logic        take_o, gie_o;
  logic [11:0] vector_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_flags, m_mask;
  logic       m_gie, m_s1, m_s2, m_prev;

  always #10 clk_i = ~clk_i;

  mcu_irq_ctrl u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_take();
    return m_gie & (swi_i | (|(m_flags & m_mask)));
  endfunction

  function automatic logic [11:0] exp_vec();
    return swi_i ? 12'h002 : 12'h001;
  endfunction

  task automatic idle();
    tmr_ovf_i = 0; eni_i = 0; disi_i = 0; reti_i = 0; swi_i = 0;
    stat_wr_i = 0; mask_wr_i = 0; stat_wdata_i = '0; mask_wdata_i = '0;
  endtask

  task automatic model_reset();
    m_flags = '0; m_mask = '0; m_gie = 0; m_s1 = 1; m_s2 = 1; m_prev = 1;
  endtask

  // check combinational outputs, take one edge, update model, back at negedge
  task automatic step();
    logic fall, tk;
    logic [7:0] nf;
    #1;
    chk("R4", stat_rdata_o, m_flags & m_mask);
    chk("R4", mask_rdata_o, m_mask);
    tk = exp_take();
    chk("R7", take_o, tk);
    if (tk) chk("R8", vector_o, exp_vec());
    chk("R6", gie_o, m_gie);
    @(posedge clk_i);
    fall = m_prev & ~m_s2;
    nf = stat_wr_i ? (m_flags & stat_wdata_i) : m_flags;
    nf = (nf | {4'b0, fall, 2'b0, tmr_ovf_i}) & 8'h09;
    if (mask_wr_i) m_mask = mask_wdata_i & 8'h09;
    if (tk || disi_i) m_gie = 0;
    else if (eni_i || reti_i) m_gie = 1;
    m_flags = nf;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_irq_ni;
    @(negedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); ext_irq_ni = 1; model_reset();
    #25;
    chk("R1", stat_rdata_o, 0); chk("R1", mask_rdata_o, 0);
    chk("R1", gie_o, 0); chk("R1", take_o, 0);
    @(negedge clk_i); rst_ni = 1; step();
    chk("R1", gie_o, 0);

    // R2: timer flag latches while masked and globally disabled
    tmr_ovf_i = 1; step(); idle();
    chk("R4", stat_rdata_o, 0);
    mask_wr_i = 1; mask_wdata_i = 8'hFF; step(); idle();
    chk("R4", mask_rdata_o, 8'h09);
    chk("R2", stat_rdata_o, 8'h01);
    chk("R7", take_o, 0);

    // R5: writing ones does not set the external flag; a zero clears timer
    stat_wr_i = 1; stat_wdata_i = 8'hFF; step(); idle();
    chk("R5", stat_rdata_o, 8'h01);
    stat_wr_i = 1; stat_wdata_i = 8'h00; tmr_ovf_i = 1; step(); idle();
    chk("R5", stat_rdata_o, 8'h01);
    stat_wr_i = 1; stat_wdata_i = 8'h00; step(); idle();
    chk("R5", stat_rdata_o, 8'h00);

    // R3: falling pin reaches the flag on the third edge
    ext_irq_ni = 0; step(); chk("R3", stat_rdata_o, 0);
    step(); chk("R3", stat_rdata_o, 0);
    step(); chk("R3", stat_rdata_o, 8'h08);
    stat_wr_i = 1; stat_wdata_i = 8'h00; step(); idle();
    step(); step(); chk("R3", stat_rdata_o, 0);
    ext_irq_ni = 1; step(); step(); step(); step();
    chk("R3", stat_rdata_o, 0);

    // R6: disable wins over enable
    eni_i = 1; disi_i = 1; step(); idle(); chk("R6", gie_o, 0);
    reti_i = 1; step(); idle(); chk("R6", gie_o, 1);

    // R8: software request beats pending hardware, flag stays
    tmr_ovf_i = 1; step(); idle();
    swi_i = 1; #1; chk("R8", take_o, 1); chk("R8", vector_o, 12'h002);
    eni_i = 1; step(); idle();
    chk("R9", gie_o, 0);
    chk("R8", stat_rdata_o, 8'h01);
    swi_i = 1; #1; chk("R8", take_o, 0); step(); idle();
    eni_i = 1; step(); idle();
    #1; chk("R7", take_o, 1); chk("R7", vector_o, 12'h001);
    step(); chk("R9", gie_o, 0);
    stat_wr_i = 1; stat_wdata_i = 0; step(); idle();

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      tmr_ovf_i    = ($urandom % 6) == 0;
      if (($urandom % 8) == 0) ext_irq_ni = ~ext_irq_ni;
      eni_i        = ($urandom % 4) == 0;
      disi_i       = ($urandom % 7) == 0;
      reti_i       = ($urandom % 9) == 0;
      swi_i        = ($urandom % 10) == 0;
      stat_wr_i    = ($urandom % 5) == 0;
      stat_wdata_i = 8'($urandom);
      mask_wr_i    = ($urandom % 12) == 0;
      mask_wdata_i = 8'($urandom);
      step();
    end
    idle(); step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule